// File: doc/BRIEF.md
# Multi-Bank Clock Divider with Feedback Output

This block turns one source clock into four banks of four clock outputs each, plus a single feedback clock. Each bank divides the source by 3, 4, 6 or 12, picked by the bank's own 2-bit code. The feedback output divides by 6, 12, 16 or 20 under a separate 2-bit code. The divide-by-3 output keeps a 50% duty cycle. To do this it stretches the high phase by half a source period with a falling-edge flop.

The source clock has three possible origins. In PLL mode the block uses the internal oscillator clock. In bypass mode it uses one of two reference clocks, either the crystal clock or the external reference, taken without any multiplication. An active-high master reset holds every divider and drives every clock output low. All dividers leave reset on the same source edge, so the banks stay phase-aligned. Each bank has an output enable. The block does not drive pads, so it reports the enable on a per-bank drive-enable output, and the pad ring turns that into a high-impedance state.

Top module: `clk_bank_divider`

## Requirements
- R1: The source clock is `osc_clk` when `pll_mode` is 1. When `pll_mode` is 0 it is `xtal_clk` if `ref_sel` is 1 and `ext_ref_clk` if `ref_sel` is 0. The dividers act on the selected source in every mode.
- R2: Bank b takes its divide code from `bank_div_sel[2b+1:2b]`. Code 0 divides by 3, code 1 by 4, code 2 by 6 and code 3 by 12. Each bank's code is independent of the others.
- R3: The feedback divide code `fb_div_sel` maps code 0 to divide by 6, code 1 to 12, code 2 to 16 and code 3 to 20.
- R4: After reset is released, every output rises on the first source rising edge. For an even ratio N it stays high for N/2 source periods, then low for N/2 source periods, and repeats.
- R5: For divide by 3, the output rises on a source rising edge and falls on the source falling edge one and a half periods later. It then stays low for one and a half periods.
- R6: While `mst_rst` is 1, every bank output and `fb_clk` is 0, and the dividers hold their reset state.
- R7: `bank_oe[b]` follows `bank_en[b]` at all times, including while reset is active.
- R8: The four outputs of a bank are always identical.
- R9: A new divide code is taken only when the divider wraps after its last count of the current period. The period in progress finishes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Internal oscillator clock, used in PLL mode |
| xtal_clk | input | 1 | Crystal reference clock |
| ext_ref_clk | input | 1 | External reference clock |
| pll_mode | input | 1 | 1 = oscillator source, 0 = bypass to a reference |
| ref_sel | input | 1 | Picks the reference: 1 = crystal, 0 = external |
| mst_rst | input | 1 | Active-high master reset of all dividers |
| bank_div_sel | input | 2*NBANK | Two-bit divide code per bank |
| bank_en | input | NBANK | Output enable per bank |
| fb_div_sel | input | 2 | Feedback divide code |
| bank_clk | output | NBANK*LANES | Bank clocks, bank b on bits [LANES*b +: LANES] |
| bank_oe | output | NBANK | Drive enable per bank (0 = high impedance) |
| fb_clk | output | 1 | Feedback clock |

## Verification
The bench samples every output half a source period apart. This catches a divide-by-3 stuck at a 33% duty cycle: the falling-edge stretch would be missing and the sample after the second rising edge would read low. Divide codes are changed at random points inside a period. A divider that applied a new code at once would produce a short or long period, and the bench's wrap-aligned model flags it. Both bypass references run at periods different from the oscillator. A wrong source mux would therefore shift every edge of the expected waveform. Reset pulses with random enables check that outputs read low under reset and that the enables still pass through.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int RW = 5;

    typedef logic [1:0] code_t;

    typedef struct packed {
        logic [RW-1:0] cnt;
        code_t         code;
        logic          hi;
    } div_state_t;

    function automatic logic [RW-1:0] pick_ratio(input logic [4*RW-1:0] tbl, input code_t code);
        return tbl[code*RW +: RW];
    endfunction

    function automatic bit has_odd(input logic [4*RW-1:0] tbl);
        bit any = 1'b0;
        for (int i = 0; i < 4; i++) begin
            any = any | tbl[i*RW];
        end
        return any;
    endfunction

endpackage

// File: rtl/src_select.sv
module src_select (
    input  logic osc_clk,
    input  logic xtal_clk,
    input  logic ext_ref_clk,
    input  logic pll_mode,
    input  logic ref_sel,
    output logic src_clk
);
    logic ref_clk;

    always_comb begin
        ref_clk = ref_sel ? xtal_clk : ext_ref_clk;
        src_clk = pll_mode ? osc_clk : ref_clk;
    end
endmodule

// File: rtl/ratio_divider.sv
module ratio_divider
    import clkdiv_pkg::*;
#(
    parameter logic [4*RW-1:0] RATIOS = {5'd12, 5'd6, 5'd4, 5'd3}
) (
    input  logic  clk,
    input  logic  rst,
    input  code_t sel,
    output logic  clk_o
);
    localparam logic [RW-1:0] RESET_CNT = pick_ratio(RATIOS, 2'b11) - RW'(1);
    localparam bit            HAS_ODD   = has_odd(RATIOS);

    div_state_t    st_d, st_q;
    logic [RW-1:0] n_cur, n_nxt;
    logic          stretch;

    always_comb begin
        n_cur = pick_ratio(RATIOS, st_q.code);
        st_d  = st_q;
        if (st_q.cnt == n_cur - RW'(1)) begin
            st_d.cnt  = '0;
            st_d.code = sel;
        end else begin
            st_d.cnt  = st_q.cnt + RW'(1);
        end
        n_nxt   = pick_ratio(RATIOS, st_d.code);
        st_d.hi = (st_d.cnt < (n_nxt >> 1));
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '{cnt: RESET_CNT, code: 2'b11, hi: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (HAS_ODD) begin : g_odd
            logic half_q;
            always_ff @(negedge clk or posedge rst) begin
                if (rst) begin
                    half_q <= 1'b0;
                end else begin
                    half_q <= st_q.hi;
                end
            end
            assign stretch = half_q & n_cur[0];
        end else begin : g_even
            assign stretch = 1'b0;
        end
    endgenerate

    assign clk_o = st_q.hi | stretch;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < n_cur);                                          // R4
    AST_CODE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (st_q.code != $past(st_q.code)) |-> (st_q.cnt == '0));      // R9
    AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.hi) |-> (st_q.cnt == '0));                       // R4
    AST_RESET_LOW: assert property (@(posedge clk)
        rst |-> !clk_o);                                            // R6
endmodule

// File: rtl/out_bank.sv
module out_bank
    import clkdiv_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  code_t            sel,
    input  logic             en,
    output logic [LANES-1:0] lanes,
    output logic             oe
);
    logic div_clk;

    ratio_divider #(.RATIOS({5'd12, 5'd6, 5'd4, 5'd3})) u_div (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .clk_o (div_clk)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign lanes[l] = div_clk;
        end
    endgenerate

    assign oe = en;
endmodule

// File: rtl/clk_bank_divider.sv
module clk_bank_divider
    import clkdiv_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int LANES = 4
) (
    input  logic                   osc_clk,
    input  logic                   xtal_clk,
    input  logic                   ext_ref_clk,
    input  logic                   pll_mode,
    input  logic                   ref_sel,
    input  logic                   mst_rst,
    input  logic [2*NBANK-1:0]     bank_div_sel,
    input  logic [NBANK-1:0]       bank_en,
    input  logic [1:0]             fb_div_sel,
    output logic [NBANK*LANES-1:0] bank_clk,
    output logic [NBANK-1:0]       bank_oe,
    output logic                   fb_clk
);
    localparam int OUT_W = NBANK * LANES;

    logic src_clk;

    src_select u_src (
        .osc_clk     (osc_clk),
        .xtal_clk    (xtal_clk),
        .ext_ref_clk (ext_ref_clk),
        .pll_mode    (pll_mode),
        .ref_sel     (ref_sel),
        .src_clk     (src_clk)
    );

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            out_bank #(.LANES(LANES)) u_bank (
                .clk   (src_clk),
                .rst   (mst_rst),
                .sel   (bank_div_sel[2*b +: 2]),
                .en    (bank_en[b]),
                .lanes (bank_clk[LANES*b +: LANES]),
                .oe    (bank_oe[b])
            );
        end
    endgenerate

    ratio_divider #(.RATIOS({5'd20, 5'd16, 5'd12, 5'd6})) u_fb (
        .clk   (src_clk),
        .rst   (mst_rst),
        .sel   (fb_div_sel),
        .clk_o (fb_clk)
    );

    AST_ALL_LOW_IN_RESET: assert property (@(posedge src_clk)
        mst_rst |-> (bank_clk == OUT_W'(0)) && !fb_clk);            // R6
endmodule

// File: tb/clk_bank_divider_test.sv
module clk_bank_divider_test;
    localparam int NB = 4;
    localparam int LN = 4;

    logic           osc_clk = 1'b0;
    logic           xtal_clk = 1'b0;
    logic           ext_ref_clk = 1'b0;
    logic           pll_mode = 1'b1;
    logic           ref_sel = 1'b0;
    logic           mst_rst = 1'b1;
    logic [2*NB-1:0] bank_div_sel = '0;
    logic [NB-1:0]  bank_en = '1;
    logic [1:0]     fb_div_sel = '0;
    logic [NB*LN-1:0] bank_clk;
    logic [NB-1:0]  bank_oe;
    logic           fb_clk;

    clk_bank_divider uut (
        .osc_clk(osc_clk), .xtal_clk(xtal_clk), .ext_ref_clk(ext_ref_clk),
        .pll_mode(pll_mode), .ref_sel(ref_sel), .mst_rst(mst_rst),
        .bank_div_sel(bank_div_sel), .bank_en(bank_en), .fb_div_sel(fb_div_sel),
        .bank_clk(bank_clk), .bank_oe(bank_oe), .fb_clk(fb_clk)
    );

    always #5  osc_clk = ~osc_clk;       // 100 MHz
    always #7  ext_ref_clk = ~ext_ref_clk;
    always #11 xtal_clk = ~xtal_clk;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    int m_cnt [NB+1];
    int m_code[NB+1];

    // R2 bank code table, R3 feedback code table (index NB is feedback)
    function automatic int ratio_of(int idx, int code);
        if (idx == NB) begin
            case (code) 0: return 6; 1: return 12; 2: return 16; default: return 20; endcase
        end
        case (code) 0: return 3; 1: return 4; 2: return 6; default: return 12; endcase
    endfunction

    function automatic int sel_of(int idx);
        if (idx == NB) return int'(fb_div_sel);
        return int'(bank_div_sel[2*idx +: 2]);
    endfunction

    // R4 even waveform, R5 half-period stretch for odd ratios
    function automatic logic exp_level(int idx, bit after_fall);
        int n = ratio_of(idx, m_code[idx]);
        if (mst_rst) return 1'b0;
        if (!after_fall && (n % 2 == 1)) return (m_cnt[idx] <= n / 2);
        return (m_cnt[idx] < n / 2);
    endfunction

    task automatic model_reset();
        for (int i = 0; i <= NB; i++) begin
            m_code[i] = 3;
            m_cnt[i]  = ratio_of(i, 3) - 1;
        end
    endtask

    task automatic model_edge();
        if (mst_rst) return;
        for (int i = 0; i <= NB; i++) begin
            if (m_cnt[i] == ratio_of(i, m_code[i]) - 1) begin
                m_cnt[i]  = 0;
                m_code[i] = sel_of(i);   // R9 new code taken at wrap only
            end else begin
                m_cnt[i]++;
            end
        end
    endtask

    task automatic check4(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic compare(bit after_fall);
        string tag;
        logic  lvl;
        for (int b = 0; b < NB; b++) begin
            lvl = exp_level(b, after_fall);
            if (mst_rst) tag = "R6";
            else if (sel_of(b) != m_code[b]) tag = "R9";
            else if (!pll_mode) tag = "R1";
            else if (ratio_of(b, m_code[b]) == 3) tag = "R5";
            else tag = "R2 R4";
            check4($sformatf("%s bank%0d", tag, b), bank_clk[LN*b +: LN], {LN{lvl}});
            check4("R8 lanes", bank_clk[LN*b +: LN], {LN{bank_clk[LN*b]}});
        end
        check4(mst_rst ? "R6 fb" : "R3 fb", {3'b000, fb_clk}, {3'b000, exp_level(NB, after_fall)});
        check4("R7 oe", bank_oe, bank_en);
    endtask

    task automatic wait_src(bit rise);
        if (pll_mode) begin
            if (rise) @(posedge osc_clk); else @(negedge osc_clk);
        end else if (ref_sel) begin
            if (rise) @(posedge xtal_clk); else @(negedge xtal_clk);
        end else begin
            if (rise) @(posedge ext_ref_clk); else @(negedge ext_ref_clk);
        end
    endtask

    task automatic tick(int n);
        for (int k = 0; k < n; k++) begin
            wait_src(1'b1);
            model_edge();
            #1 compare(1'b0);
            wait_src(1'b0);
            #1 compare(1'b1);
        end
    endtask

    task automatic enter_reset(bit pm, bit rs);
        mst_rst = 1'b1;
        model_reset();
        #2;
        pll_mode = pm;
        ref_sel  = rs;
        tick(3);
    endtask

    task automatic leave_reset();
        mst_rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        bank_en = 4'b1010;
        tick(4);                               // R6 R7 reset state
        // directed: every bank code at once, PLL mode
        bank_div_sel = 8'b11_10_01_00;
        fb_div_sel   = 2'd0;
        bank_en      = '1;
        leave_reset();
        tick(60);
        for (int f = 1; f < 4; f++) begin      // R3 all feedback codes
            enter_reset(1'b1, 1'b0);
            fb_div_sel   = 2'(f);
            bank_div_sel = {bank_div_sel[5:0], bank_div_sel[7:6]};
            leave_reset();
            tick(50);
        end
        // R9: switch bank0 from /12 to /3 mid-period
        enter_reset(1'b1, 1'b0);
        bank_div_sel = 8'b00_00_00_11;
        leave_reset();
        tick(2);
        bank_div_sel[1:0] = 2'b00;
        tick(30);
        // R1 bypass through both references
        enter_reset(1'b0, 1'b0);
        bank_div_sel = 8'b00_01_10_11;
        leave_reset();
        tick(40);
        enter_reset(1'b0, 1'b1);
        leave_reset();
        tick(40);
        bank_en = 4'b0101;                     // R7 enables while running
        tick(5);
        // random segments
        for (int s = 0; s < 80; s++) begin
            if ($urandom_range(0, 5) == 0) begin
                enter_reset(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
                bank_en = 4'($urandom);
                leave_reset();
            end
            if ($urandom_range(0, 1) == 1) bank_div_sel = 8'($urandom);
            if ($urandom_range(0, 2) == 0) fb_div_sel = 2'($urandom);
            bank_en = 4'($urandom);
            tick(int'($urandom_range(5, 40)));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired at %0t: actual running expected done", $time);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule